// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block keeps a small set of recent virtual-to-physical page translations close to the pipeline. A requester presents a 32-bit virtual address, the identifier of the running process and an access type. All entries are compared at once against both the page number and the process identifier. When one of them matches, the block returns a physical address in the same cycle, together with the stored permission and status bits. Translations of several processes can stay resident side by side, so a process switch does not force the whole cache to be cleared.

When nothing matches, the block reports a miss. An outside table walker resolves the page and then writes the translation in through a fill port. A write access to a page whose permissions forbid writing is reported as a protection fault and does not count as a hit. A flush port removes, in one cycle, every translation that belongs to a given process. The default build has 4 KB pages, 16 entries and 8-bit process identifiers.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: While `lk_req` is high, exactly one of `lk_hit`, `lk_miss` and `lk_pfault` is high. While `lk_req` is low, all three are low, and the cycle changes no status bit, whatever the other lookup inputs are.
- R3: An entry matches only when it is valid and both its page number (address bits 31:12) and its process identifier equal the lookup inputs. The result appears in the same cycle as the request.
- R4: On a hit, `lk_paddr` is the stored frame number in bits 31:12 followed by `lk_vaddr[11:0]` unchanged. On a hit or a fault, `lk_perm` carries the stored permission bits.
- R5: Permission bit 1 means the page is writable. A write lookup (`lk_wr`=1) that matches an entry with bit 1 clear raises `lk_pfault` instead of `lk_hit` and leaves the entry's modified and referenced bits unchanged. Reads are always permitted.
- R6: Every hit sets the entry's referenced bit. A write hit also sets its modified bit. `lk_mod` and `lk_ref` show the bits as they stood before the current access, so an update is visible from the next lookup onward.
- R7: A fill stores the page number, process identifier, frame number and permission bits, and clears the modified and referenced bits. The fill goes to the entry that already matches the same page and process if there is one. Otherwise it goes to the lowest-numbered invalid entry. Otherwise it goes to the entry the replacement pointer selects.
- R8: The replacement pointer is 0 after reset. It advances by one, wrapping after the last entry, only when a fill overwrites a valid, non-matching entry.
- R9: A flush invalidates, in one cycle, every entry tagged with `flush_pid`. A fill in the same cycle picks its slot from the entries as they stood before the flush, is applied after the flush, and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process identifier of the requester |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No matching entry |
| lk_pfault | output | 1 | Matching entry forbids the write |
| lk_paddr | output | 32 | Translated physical address |
| lk_perm | output | 2 | Stored permission bits (bit 1 = writable) |
| lk_mod | output | 1 | Stored modified bit before this access |
| lk_ref | output | 1 | Stored referenced bit before this access |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number to store |
| fill_pid | input | 8 | Process identifier to store |
| fill_pfn | input | 20 | Frame number to store |
| fill_perm | input | 2 | Permission bits to store |
| flush_en | input | 1 | Invalidate one process's entries |
| flush_pid | input | 8 | Process whose entries are invalidated |

## Verification
The bench builds the block with its default parameters: 16 entries, 8-bit process identifiers and 4 KB pages. The table is small enough that sweeps can fill every slot, reach full occupancy and then look up each resident page with varied offsets, wrong identifiers and neighbouring page numbers. At full occupancy, the order of evictions under round-robin replacement can be predicted from the fill sequence alone. This lets the bench check the first-invalid rule, the refill of a page that is already resident, and a fill combined with a flush, all through later lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_MISS  = 2'd2,
    LK_FAULT = 2'd3
  } lk_res_e;
endpackage

// File: rtl/xlat_enc.sv
// Lowest-index priority encoder.
module xlat_enc #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_cam.sv
// Parallel compare of one key against every entry.
module xlat_cam #(
  parameter int N     = 16,
  parameter int PID_W = 8,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][PID_W-1:0] pid_tab,
  input  logic [N-1:0][VPN_W-1:0] vpn_tab,
  input  logic [PID_W-1:0]        key_pid,
  input  logic [VPN_W-1:0]        key_vpn,
  output logic [N-1:0]            match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (pid_tab[g] == key_pid) && (vpn_tab[g] == key_vpn);
  end
endmodule

// File: rtl/xlat_victim.sv
// Fill slot choice: existing match, else lowest invalid, else round-robin.
module xlat_victim #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          fill_en,
  input  logic [N-1:0]  fill_match,
  output logic [IW-1:0] slot,
  output logic [IW-1:0] rr_ptr
);
  logic [IW-1:0] m_idx, inv_idx, rr_q, rr_d;
  logic          m_any, inv_any, rr_adv;

  xlat_enc #(.N(N), .IW(IW)) u_menc (.vec(fill_match), .idx(m_idx),   .any(m_any));
  xlat_enc #(.N(N), .IW(IW)) u_ienc (.vec(~vld),       .idx(inv_idx), .any(inv_any));

  always_comb begin
    if (m_any)        slot = m_idx;
    else if (inv_any) slot = inv_idx;
    else              slot = rr_q;
  end

  assign rr_adv = fill_en && !m_any && !inv_any;

  always_comb begin
    rr_d = rr_q;
    if (rr_adv) begin
      if (rr_q == IW'(N - 1)) rr_d = '0;
      else                    rr_d = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rr_q <= '0;
    else if (rr_adv) rr_q <= rr_d;
  end

  assign rr_ptr = rr_q;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8,
  parameter int PERM_W  = 2,
  parameter int WR_BIT  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_req,
  input  logic                  lk_wr,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [PID_W-1:0]      lk_pid,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic                  lk_pfault,
  output logic [PA_W-1:0]       lk_paddr,
  output logic [PERM_W-1:0]     lk_perm,
  output logic                  lk_mod,
  output logic                  lk_ref,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PID_W-1:0]      fill_pid,
  input  logic [PA_W-OFF_W-1:0] fill_pfn,
  input  logic [PERM_W-1:0]     fill_perm,
  input  logic                  flush_en,
  input  logic [PID_W-1:0]      flush_pid
);
  import xlat_pkg::*;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // synchronised reset release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // entry storage
  logic [ENTRIES-1:0]             vld_q, vld_d, mod_q, mod_d, ref_q, ref_d;
  logic [ENTRIES-1:0][PID_W-1:0]  pid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  // lookup path
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IW-1:0]      lk_idx, fill_slot, rr_ptr;
  logic               lk_any;
  lk_res_e            lk_res;

  xlat_cam #(.N(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_lk_cam (
    .vld(vld_q), .pid_tab(pid_q), .vpn_tab(vpn_q),
    .key_pid(lk_pid), .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .match(lk_match));

  xlat_enc #(.N(ENTRIES), .IW(IW)) u_lk_enc (.vec(lk_match), .idx(lk_idx), .any(lk_any));

  always_comb begin
    lk_res = LK_IDLE;
    if (lk_req) begin
      if (!lk_any)                                 lk_res = LK_MISS;
      else if (lk_wr && !perm_q[lk_idx][WR_BIT])   lk_res = LK_FAULT;
      else                                         lk_res = LK_HIT;
    end
  end

  logic lk_found;
  assign lk_found  = (lk_res == LK_HIT) || (lk_res == LK_FAULT);
  assign lk_hit    = (lk_res == LK_HIT);
  assign lk_miss   = (lk_res == LK_MISS);
  assign lk_pfault = (lk_res == LK_FAULT);
  assign lk_paddr  = {pfn_q[lk_idx], lk_vaddr[OFF_W-1:0]};
  assign lk_perm   = lk_found ? perm_q[lk_idx] : '0;
  assign lk_mod    = lk_found && mod_q[lk_idx];
  assign lk_ref    = lk_found && ref_q[lk_idx];

  // fill slot choice
  xlat_cam #(.N(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_fl_cam (
    .vld(vld_q), .pid_tab(pid_q), .vpn_tab(vpn_q),
    .key_pid(fill_pid), .key_vpn(fill_vpn), .match(fl_match));

  xlat_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_sync_n), .vld(vld_q), .fill_en(fill_en),
    .fill_match(fl_match), .slot(fill_slot), .rr_ptr(rr_ptr));

  // next state of the status bits: access update, then flush, then fill
  always_comb begin
    vld_d = vld_q;
    mod_d = mod_q;
    ref_d = ref_q;
    if (lk_hit) begin
      ref_d[lk_idx] = 1'b1;
      if (lk_wr) mod_d[lk_idx] = 1'b1;
    end
    if (flush_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (pid_q[i] == flush_pid) vld_d[i] = 1'b0;
      end
    end
    if (fill_en) begin
      vld_d[fill_slot] = 1'b1;
      mod_d[fill_slot] = 1'b0;
      ref_d[fill_slot] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= '0;
      mod_q <= '0;
      ref_q <= '0;
    end else begin
      vld_q <= vld_d;
      mod_q <= mod_d;
      ref_q <= ref_d;
    end
  end

  // payload: no reset, written under the fill enable
  always_ff @(posedge clk) begin
    if (fill_en && rst_sync_n) begin
      pid_q[fill_slot]  <= fill_pid;
      vpn_q[fill_slot]  <= fill_vpn;
      pfn_q[fill_slot]  <= fill_pfn;
      perm_q[fill_slot] <= fill_perm;
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PID_W  = 8,
  parameter int PERM_W = 2,
  parameter int WR_BIT = 1,
  parameter int IW     = 4
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  lk_req,
  input logic                  lk_wr,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic [PID_W-1:0]      lk_pid,
  input logic                  lk_hit,
  input logic                  lk_miss,
  input logic                  lk_pfault,
  input logic [PA_W-1:0]       lk_paddr,
  input logic [PERM_W-1:0]     lk_perm,
  input logic                  lk_mod,
  input logic                  fill_en,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic [PID_W-1:0]      fill_pid,
  input logic [PA_W-OFF_W-1:0] fill_pfn,
  input logic                  flush_en,
  input logic [PID_W-1:0]      flush_pid,
  input logic [IW-1:0]         rr_ptr
);
  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_req |-> $countones({lk_hit, lk_miss, lk_pfault}) == 1);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_req |-> !lk_hit && !lk_miss && !lk_pfault);

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  assert_fault_only_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_pfault |-> lk_wr && !lk_perm[WR_BIT]);

  assert_fill_visible_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(fill_en) && lk_req && !lk_wr
     && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn) && lk_pid == $past(fill_pid))
    |-> lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_pfn));

  assert_write_marks_mod_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(lk_hit && lk_wr) && !$past(fill_en) && !$past(flush_en) && lk_req
     && lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W])
     && lk_pid == $past(lk_pid)) |-> lk_mod);

  assert_flush_removes_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(flush_en) && !$past(fill_en) && lk_req && lk_pid == $past(flush_pid))
    |-> lk_miss);

  assert_rr_moves_on_fill_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(fill_en) |-> $stable(rr_ptr));
endmodule

bind xlat_tlb xlat_tlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PID_W(PID_W),
  .PERM_W(PERM_W), .WR_BIT(WR_BIT), .IW(IW)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .lk_req(lk_req), .lk_wr(lk_wr),
  .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_pfault(lk_pfault), .lk_paddr(lk_paddr), .lk_perm(lk_perm), .lk_mod(lk_mod),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
  .flush_en(flush_en), .flush_pid(flush_pid), .rr_ptr(rr_ptr)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  localparam int K_MISS  = 0;
  localparam int K_HIT   = 1;
  localparam int K_FAULT = 2;

  logic        clk, rst_n;
  logic        lk_req, lk_wr;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_pid;
  logic        lk_hit, lk_miss, lk_pfault;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_perm;
  logic        lk_mod, lk_ref;
  logic        fill_en;
  logic [19:0] fill_vpn, fill_pfn;
  logic [7:0]  fill_pid;
  logic [1:0]  fill_perm;
  logic        flush_en;
  logic [7:0]  flush_pid;

  int total = 0;
  int bad   = 0;

  xlat_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_wr(lk_wr),
    .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pfault(lk_pfault), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
    .lk_mod(lk_mod), .lk_ref(lk_ref), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush_en(flush_en), .flush_pid(flush_pid));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [19:0] vpn_of(int i);  return 20'h00010 + 20'(i * 3);   endfunction
  function automatic logic [7:0]  pid_of(int i);  return 8'h10 + 8'(i % 4);        endfunction
  function automatic logic [19:0] pfn_of(int i);  return 20'hA0000 + 20'(i * 7);   endfunction
  function automatic logic [1:0]  perm_of(int i); return (i % 2 == 0) ? 2'b11 : 2'b01; endfunction
  function automatic logic [11:0] off_of(int i);  return 12'((i * 257 + 5) % 4096); endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // exp_mod / exp_ref of -1 skip that check
  task automatic look(input string req, input logic [19:0] vpn, input logic [11:0] off,
                      input logic [7:0] pid, input logic wr, input int kind,
                      input logic [19:0] epfn, input logic [1:0] eperm,
                      input int emod, input int eref);
    @(negedge clk);
    lk_req = 1'b1; lk_wr = wr; lk_vaddr = {vpn, off}; lk_pid = pid;
    #2;
    chk(req, "result", {61'd0, lk_pfault, lk_hit, lk_miss},
        (kind == K_HIT) ? 64'd2 : (kind == K_FAULT) ? 64'd4 : 64'd1);
    if (kind == K_HIT) chk(req, "paddr", {32'd0, lk_paddr}, {32'd0, epfn, off});
    if (kind != K_MISS) begin
      chk(req, "perm", {62'd0, lk_perm}, {62'd0, eperm});
      if (emod >= 0) chk(req, "mod", {63'd0, lk_mod}, 64'(emod));
      if (eref >= 0) chk(req, "ref", {63'd0, lk_ref}, 64'(eref));
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] pfn,
                      input logic [1:0] perm, input logic fl, input logic [7:0] fpid);
    @(negedge clk);
    lk_req = 1'b0;
    fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn; fill_perm = perm;
    flush_en = fl; flush_pid = fpid;
    @(negedge clk);
    fill_en = 1'b0; flush_en = 1'b0;
  endtask

  task automatic flush(input logic [7:0] fpid);
    @(negedge clk);
    lk_req = 1'b0; flush_en = 1'b1; flush_pid = fpid;
    @(negedge clk);
    flush_en = 1'b0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_wr = 1'b0; lk_vaddr = '0; lk_pid = '0;
    fill_en = 1'b0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0; fill_perm = '0;
    flush_en = 1'b0; flush_pid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: empty after reset
    look("R1", vpn_of(0), off_of(0), pid_of(0), 1'b0, K_MISS, '0, '0, -1, -1);

    for (int i = 0; i < 16; i++) fill(vpn_of(i), pid_of(i), pfn_of(i), perm_of(i), 1'b0, 8'h00);

    // R2: idle write-looking cycle gives no result and leaves state alone
    @(negedge clk);
    lk_req = 1'b0; lk_wr = 1'b1; lk_vaddr = {vpn_of(0), 12'h000}; lk_pid = pid_of(0);
    #2;
    chk("R2", "idle outputs", {61'd0, lk_pfault, lk_hit, lk_miss}, 64'd0);

    // R3 R4 R6: every slot hits on reads, bits still clear
    for (int i = 0; i < 16; i++)
      look("R3", vpn_of(i), off_of(i), pid_of(i), 1'b0, K_HIT, pfn_of(i), perm_of(i), 0, 0);
    // R3: wrong identifier or neighbouring page misses
    for (int i = 0; i < 16; i++) begin
      look("R3", vpn_of(i), off_of(i), pid_of(i) ^ 8'h80, 1'b0, K_MISS, '0, '0, -1, -1);
      look("R3", vpn_of(i) + 20'd1, off_of(i), pid_of(i), 1'b0, K_MISS, '0, '0, -1, -1);
    end
    // R5: writes hit writable pages, fault on read-only ones
    for (int i = 0; i < 16; i++)
      look("R5", vpn_of(i), off_of(i + 3), pid_of(i), 1'b1,
           (i % 2 == 0) ? K_HIT : K_FAULT, pfn_of(i), perm_of(i), 0, 1);
    // R6: modified set only by permitted writes
    for (int i = 0; i < 16; i++)
      look("R6", vpn_of(i), off_of(i + 7), pid_of(i), 1'b0, K_HIT, pfn_of(i), perm_of(i),
           (i % 2 == 0) ? 1 : 0, 1);

    // R9: flush one process
    flush(8'h11);
    for (int i = 0; i < 16; i++)
      look("R9", vpn_of(i), off_of(i), pid_of(i), 1'b0,
           (i % 4 == 1) ? K_MISS : K_HIT, pfn_of(i), perm_of(i), -1, -1);

    // R7: refills land in freed slots 1,5,9,13 (lowest invalid first)
    for (int k = 0; k < 4; k++) fill(20'h00800 + 20'(k), 8'h20, 20'h0B000 + 20'(k), 2'b11, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++)
      look("R7", 20'h00800 + 20'(k), 12'h3C4, 8'h20, 1'b0, K_HIT, 20'h0B000 + 20'(k), 2'b11, 0, 0);

    // R8: full table, round-robin from 0: slots 0,1,2 replaced
    for (int k = 0; k < 3; k++) fill(20'h00900 + 20'(k), 8'h21, 20'h0C000 + 20'(k), 2'b11, 1'b0, 8'h00);
    look("R8", vpn_of(0), 12'h001, pid_of(0), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R8", 20'h00800, 12'h001, 8'h20, 1'b0, K_MISS, '0, '0, -1, -1);
    look("R8", vpn_of(2), 12'h001, pid_of(2), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R8", 20'h00801, 12'h001, 8'h20, 1'b0, K_HIT, 20'h0B001, 2'b11, -1, -1);
    look("R8", vpn_of(3), 12'h001, pid_of(3), 1'b0, K_HIT, pfn_of(3), perm_of(3), -1, -1);
    for (int k = 0; k < 3; k++)
      look("R8", 20'h00900 + 20'(k), 12'hFFF, 8'h21, 1'b0, K_HIT, 20'h0C000 + 20'(k), 2'b11, 0, 0);

    // R7: refill of resident page overwrites it in place and clears bits
    fill(vpn_of(3), pid_of(3), 20'h55555, 2'b11, 1'b0, 8'h00);
    look("R7", vpn_of(3), 12'hABC, pid_of(3), 1'b0, K_HIT, 20'h55555, 2'b11, 0, 0);
    // R8: pointer did not move on the refill, next victim is slot 3
    fill(20'h00903, 8'h21, 20'h0C003, 2'b11, 1'b0, 8'h00);
    look("R8", vpn_of(3), 12'h010, pid_of(3), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R8", vpn_of(4), 12'h010, pid_of(4), 1'b0, K_HIT, pfn_of(4), perm_of(4), -1, -1);
    look("R8", 20'h00903, 12'h010, 8'h21, 1'b0, K_HIT, 20'h0C003, 2'b11, -1, -1);

    // R9: fill with a same-cycle flush of its own process, slot 4 replaced
    fill(20'h00A00, 8'h12, 20'h0D000, 2'b01, 1'b1, 8'h12);
    look("R9", 20'h00A00, 12'h123, 8'h12, 1'b0, K_HIT, 20'h0D000, 2'b01, 0, 0);
    look("R9", vpn_of(4), 12'h123, pid_of(4), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R9", vpn_of(6), 12'h123, pid_of(6), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R9", vpn_of(10), 12'h123, pid_of(10), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R9", vpn_of(14), 12'h123, pid_of(14), 1'b0, K_MISS, '0, '0, -1, -1);
    look("R9", vpn_of(7), 12'h123, pid_of(7), 1'b0, K_HIT, pfn_of(7), perm_of(7), -1, -1);
    // R5: write to the read-only new page faults
    look("R5", 20'h00A00, 12'h124, 8'h12, 1'b1, K_FAULT, '0, 2'b01, 0, 1);

    @(negedge clk);
    lk_req = 1'b0;
    summary();
    $finish;
  end
endmodule